// File: doc/BRIEF.md
# Double-Buffered Converter Input Register

This block holds the digital code for a 16-bit parallel-load converter in two ranks. The front rank takes the data bus while two active-low enables are both asserted: a device select and a front-load strobe. The back rank drives the converter code. It copies the front rank while an active-high update input is asserted. Each rank is a clocked model of a transparent latch. An open rank takes its input on every clock and shows the new value one cycle later. A closed rank keeps its value.

The update input is not gated by the device select. Many instances can share one update line: each front rank is loaded in turn, and all outputs then change on the same cycle. A second use comes from tying the update input to the device select and holding the front-load strobe low. This gives an edge-triggered register. On the cycle the pair goes high, the output takes the word that was on the bus on the last cycle the pair was low.

Top module: `dbuf_dac_input_reg`

## Requirements
- R1: A synchronous reset clears both ranks to 0x0000. `code_out` reads zero after reset, and opening only the back rank afterwards still gives zero.
- R2: When `sel_n` and `load1_n` are both 0 on a clock edge, the front rank takes `din` on that edge.
- R3: When `sel_n` or `load1_n` is 1 on a clock edge, the front rank keeps its value, whatever `din` does.
- R4: When `update` is 0 on a clock edge, `code_out` does not change on that edge, even when the front rank is being reloaded.
- R5: When `update` is 1 on a clock edge, `code_out` takes the front rank's value for that edge. The output therefore changes one cycle after `update` is seen high.
- R6: `update` acts whatever the level of `sel_n`. Instances that share one `update` line change their outputs on the same cycle.
- R7: When `sel_n` = 0, `load1_n` = 0 and `update` = 1, both ranks are open and `code_out` equals the `din` of the previous cycle.
- R8: With `update` driven equal to `sel_n` and `load1_n` held at 0, the first high cycle of the pair sets `code_out` to the `din` of the last low cycle. Later `din` changes have no effect until the pair goes low again.
- R9: Bits pass through without reordering: `din[15]` (MSB) reaches `code_out[15]`, and `din[0]` (LSB) reaches `code_out[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Device select, active low, gates the front rank |
| load1_n | input | 1 | Front-rank load strobe, active low |
| update | input | 1 | Back-rank load, active high, not gated by `sel_n` |
| din | input | 16 | Parallel data word, bit 15 is the MSB |
| code_out | output | 16 | Converter code held by the back rank |

## Verification
The hardest case to reach is the shared-update case. Several front ranks must hold different words, loaded one at a time under separate selects while the common update line stays low. The outputs must stay unchanged throughout and then all change on one cycle. The bench builds three instances with their own selects and data and one shared update line, and walks this sequence directly. Edge mode is reached by driving the update line equal to the select and changing the bus on the very cycle the pair rises. A long random run then mixes every enable combination on all three instances.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    // Gate state of one latch rank
    typedef enum logic {
        RANK_HOLD = 1'b0,
        RANK_OPEN = 1'b1
    } rank_gate_e;

endpackage

// File: rtl/dbuf_gate_decode.sv
module dbuf_gate_decode
    import dbuf_pkg::*;
(
    input  logic       sel_n,
    input  logic       load1_n,
    input  logic       update,
    output rank_gate_e front_gate,
    output rank_gate_e back_gate
);

    // Front rank needs both active-low enables.
    // Back rank is deliberately not qualified by the select.
    always_comb begin
        front_gate = (!sel_n && !load1_n) ? RANK_OPEN : RANK_HOLD;
        back_gate  = update ? RANK_OPEN : RANK_HOLD;
    end

endmodule

// File: rtl/dbuf_rank.sv
module dbuf_rank
    import dbuf_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  rank_gate_e       gate,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] word_next,
    output logic [WIDTH-1:0] word_q
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } rank_state_t;

    rank_state_t state_d;
    rank_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (gate == RANK_OPEN) begin
            state_d.word = word_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // The next value is exported so a following rank can chain transparently
    assign word_next = state_d.word;
    assign word_q    = state_q.word;

endmodule

// File: rtl/dbuf_dac_input_reg.sv
module dbuf_dac_input_reg
    import dbuf_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n,
    input  logic             load1_n,
    input  logic             update,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] code_out
);

    rank_gate_e       front_gate;
    rank_gate_e       back_gate;
    logic [WIDTH-1:0] front_next;
    logic [WIDTH-1:0] front_q;
    logic [WIDTH-1:0] back_next;

    dbuf_gate_decode u_decode (
        .sel_n      (sel_n),
        .load1_n    (load1_n),
        .update     (update),
        .front_gate (front_gate),
        .back_gate  (back_gate)
    );

    dbuf_rank #(.WIDTH(WIDTH)) u_front (
        .clk       (clk),
        .rst       (rst),
        .gate      (front_gate),
        .word_in   (din),
        .word_next (front_next),
        .word_q    (front_q)
    );

    // Back rank samples the front rank's next value: with both open the bus
    // reaches the output in one cycle; with the front closed, next == held value.
    dbuf_rank #(.WIDTH(WIDTH)) u_back (
        .clk       (clk),
        .rst       (rst),
        .gate      (back_gate),
        .word_in   (front_next),
        .word_next (back_next),
        .word_q    (code_out)
    );

    logic unused_back_next;
    assign unused_back_next = ^back_next;

endmodule

// File: rtl/dbuf_dac_input_reg_chk.sv
module dbuf_dac_input_reg_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_n,
    input logic             load1_n,
    input logic             update,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] front_q,
    input logic [WIDTH-1:0] code_out
);

    a_r2_front_loads: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !load1_n) |=> (front_q == $past(din)));

    a_r3_front_holds: assert property (@(posedge clk) disable iff (rst)
        (sel_n || load1_n) |=> $stable(front_q));

    a_r4_out_holds: assert property (@(posedge clk) disable iff (rst)
        (!update) |=> $stable(code_out));

    a_r5_out_follows: assert property (@(posedge clk) disable iff (rst)
        (update && (sel_n || load1_n)) |=> (code_out == $past(front_q)));

    a_r7_flow_through: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !load1_n && update) |=> (code_out == $past(din)));

endmodule

bind dbuf_dac_input_reg dbuf_dac_input_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_n),
    .load1_n  (load1_n),
    .update   (update),
    .din      (din),
    .front_q  (front_q),
    .code_out (code_out)
);

// File: tb/dbuf_dac_input_reg_test.sv
`timescale 1ns/1ps
module dbuf_dac_input_reg_test;

    localparam int W = 16;
    localparam int N = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst;
    logic         l1_n;
    logic         upd;
    logic         sel_v [N];
    logic [W-1:0] din_v [N];
    logic [W-1:0] out_v [N];
    logic [W-1:0] mf [N];
    logic [W-1:0] mc [N];

    int checks = 0;
    int errors = 0;

    dbuf_dac_input_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .sel_n(sel_v[0]), .load1_n(l1_n),
        .update(upd), .din(din_v[0]), .code_out(out_v[0]));
    dbuf_dac_input_reg #(.WIDTH(W)) uut_b (
        .clk(clk), .rst(rst), .sel_n(sel_v[1]), .load1_n(l1_n),
        .update(upd), .din(din_v[1]), .code_out(out_v[1]));
    dbuf_dac_input_reg #(.WIDTH(W)) uut_c (
        .clk(clk), .rst(rst), .sel_n(sel_v[2]), .load1_n(l1_n),
        .update(upd), .din(din_v[2]), .code_out(out_v[2]));

    task automatic drive(input logic s0, input logic s1, input logic s2,
                         input logic l1, input logic u,
                         input logic [W-1:0] d0, input logic [W-1:0] d1,
                         input logic [W-1:0] d2);
        sel_v[0] = s0; sel_v[1] = s1; sel_v[2] = s2;
        l1_n = l1; upd = u;
        din_v[0] = d0; din_v[1] = d1; din_v[2] = d2;
    endtask

    task automatic check_val(input string req, input int i, input logic [W-1:0] exp);
        checks++;
        if (out_v[i] !== exp) begin
            errors++;
            $display("FAIL %s inst%0d actual=%h expected=%h", req, i, out_v[i], exp);
        end
    endtask

    // Advance one clock; expected values follow R1..R5 per instance
    task automatic tick(input string req);
        logic [W-1:0] fn [N];
        logic [W-1:0] cn [N];
        for (int i = 0; i < N; i++) begin
            fn[i] = (!sel_v[i] && !l1_n) ? din_v[i] : mf[i];
            cn[i] = upd ? fn[i] : mc[i];
            if (rst) begin
                fn[i] = '0;
                cn[i] = '0;
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            mf[i] = fn[i];
            mc[i] = cn[i];
            check_val(req, i, mc[i]);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] last_low;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin mf[i] = '0; mc[i] = '0; end
        rst = 1'b1;
        drive(1, 1, 1, 1, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        tick("R1");
        tick("R1");
        rst = 1'b0;
        for (int i = 0; i < N; i++) check_val("R1", i, 16'h0000);
        // open back rank only: cleared front rank must show zero
        drive(1, 1, 1, 1, 1, 16'hABCD, 16'hABCD, 16'hABCD);
        tick("R1");
        for (int i = 0; i < N; i++) check_val("R1", i, 16'h0000);

        // R4: reload front while update low; output stays
        drive(0, 0, 0, 0, 0, 16'h1234, 16'h5678, 16'h9ABC);
        tick("R4");
        drive(0, 0, 0, 0, 0, 16'h4321, 16'h8765, 16'hCBA9);
        tick("R4");
        for (int i = 0; i < N; i++) check_val("R4", i, 16'h0000);
        // R2/R5: close front, raise update -> last loaded words
        drive(1, 1, 1, 0, 1, 16'h0F0F, 16'h0F0F, 16'h0F0F);
        tick("R5");
        check_val("R2", 0, 16'h4321);
        check_val("R5", 2, 16'hCBA9);

        // R3: select high blocks load; then strobe high blocks load
        drive(1, 1, 1, 0, 1, 16'hDEAD, 16'hDEAD, 16'hDEAD);
        tick("R3");
        drive(0, 0, 0, 1, 1, 16'hBEEF, 16'hBEEF, 16'hBEEF);
        tick("R3");
        check_val("R3", 0, 16'h4321);

        // R7: everything open, one-cycle flow-through
        for (int k = 0; k < 4; k++) begin
            drive(0, 0, 0, 0, 1, 16'(k * 16'h1111 + 1), 16'(k + 7), 16'(~k));
            tick("R7");
            check_val("R7", 0, 16'(k * 16'h1111 + 1));
        end

        // R9: MSB and LSB positions
        drive(0, 0, 0, 0, 1, 16'h8000, 16'h0001, 16'h8001);
        tick("R9");
        check_val("R9", 0, 16'h8000);
        check_val("R9", 1, 16'h0001);

        // R6: load each instance separately, shared update held low
        drive(0, 1, 1, 0, 0, 16'hA001, 16'h0000, 16'h0000);
        tick("R6");
        drive(1, 0, 1, 0, 0, 16'h0000, 16'hB002, 16'h0000);
        tick("R6");
        drive(1, 1, 0, 0, 0, 16'h0000, 16'h0000, 16'hC003);
        tick("R6");
        check_val("R6", 0, 16'h8000);
        drive(1, 1, 1, 1, 1, 16'h7777, 16'h7777, 16'h7777);
        tick("R6");
        check_val("R6", 0, 16'hA001);
        check_val("R6", 1, 16'hB002);
        check_val("R6", 2, 16'hC003);

        // R8: edge mode, update tied to select, strobe low
        for (int rep = 0; rep < 3; rep++) begin
            for (int k = 0; k < 3; k++) begin
                last_low = 16'($urandom);
                drive(0, 0, 0, 0, 0, last_low, last_low, last_low);
                tick("R8");
            end
            drive(1, 1, 1, 0, 1, ~last_low, ~last_low, ~last_low);
            tick("R8");
            check_val("R8", 0, last_low);
            drive(1, 1, 1, 0, 1, 16'h5A5A, 16'h5A5A, 16'h5A5A);
            tick("R8");
            check_val("R8", 1, last_low);
        end

        // random mix of all enable combinations
        for (int k = 0; k < 600; k++) begin
            drive(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
            tick("R2 R3 R4 R5 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule